// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block collects six single-cycle interrupt event pulses into per-source flag bits. It drives one active-low interrupt request whenever a flagged source is also enabled. The sources come in two groups of three, and each group has its own control register and its own status register.

The primary group's status register clears its flags when software reads it. The value returned is frozen for the whole read cycle, which lasts while the read enable is held. Events that land during that cycle are parked and merged into the flags when the cycle ends, so no event is lost. The extended group's flags are unaffected by reads and clear only when software writes a zero to their bit positions.

A summary bit in the primary status word reports whether the interrupt line is active. It is computed from the flags and enables and is not stored. Software uses a plain synchronous read/write port to reach the registers. The event generators themselves sit outside this block.

Top module: `irq_flag_aggr`

## Requirements
- R1: After synchronous reset, all flags and enables are 0, irq_n is 1 and rd_data is 0.
- R2: A pulse on evt_pri[i] or evt_ext[i] sets flag i of its group whatever the enable bit holds.
  - The primary flags read at address 2, bits [2:0]. The extended flags read at address 3, bits [2:0].
- R3: irq_n is 0 exactly one clock after a cycle in which some source has both its flag and its enable at 1. Otherwise it is 1.
  - This includes the case where an enable is written to 1 while its flag is already set.
- R4: Read data is registered. It appears after the clock edge of the first cycle with rd_en high.
  - For a read of address 2 the word {summary at bit 7, zeros, primary flags in bits [2:0]} is captured at that edge.
  - The word stays unchanged for as long as rd_en stays high.
- R5: At the first clock edge with rd_en low after a read of address 2, every primary flag clears.
- R6: A primary event that arrives in any cycle of a read of address 2, the first cycle included, is left out of the returned word. It sets its flag at the edge that ends the read. An event in that ending cycle also sets its flag.
- R7: Reads of address 3, and reads of any address, leave the extended flags unchanged.
- R8: A write to address 3 clears extended flag i where wr_data[i] is 0 and leaves it alone where wr_data[i] is 1. An event arriving in the same cycle as a clear wins, and its flag ends set.
- R9: The summary bit (address 2, bit 7) reads 1 exactly when a source has flag and enable both set. Writes to address 2 change nothing.
- R10: Enables are written and read back at address 0, bits [2:0] for the primary group, and address 1, bits [2:0] for the extended group. All other bits of every register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable; one high run is one read cycle, addressed by addr in its first cycle |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | ADDR_W | Register address (0 primary enables, 1 extended enables, 2 primary status, 3 extended status) |
| wr_data | input | DATA_W | Write data |
| evt_pri | input | N_PRI | Single-cycle event pulses, primary group |
| evt_ext | input | N_EXT | Single-cycle event pulses, extended group |
| rd_data | output | DATA_W | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bound checker watches every cycle for four things:
- the interrupt line following the flag and enable state one clock later;
- event pulses landing in their flags outside a primary read;
- the frozen read word and frozen primary flags while a read is in progress;
- the exact flag value left after a read ends.

Other behaviours are shown only by the bench's scenarios. These are the decoded word layout and summary value for every flag and enable combination, the write-zero-to-clear masking for every mask, and the ignored writes to the primary status address. They also include the events parked at the start, middle and end of a read.

// File: rtl/irqa_pkg.sv
`timescale 1ns/1ps
package irqa_pkg;
  typedef enum logic [1:0] {
    REG_PCTL  = 2'd0,
    REG_XCTL  = 2'd1,
    REG_PSTAT = 2'd2,
    REG_XSTAT = 2'd3
  } irqa_reg_e;
endpackage

// File: rtl/irqa_enable_reg.sv
`timescale 1ns/1ps
module irqa_enable_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)         en <= '0;
    else if (wr_stb) en <= wr_bits;
  end
endmodule

// File: rtl/irqa_rc_flags.sv
`timescale 1ns/1ps
// Clear-on-read flag group with a park register for events seen during a read.
module irqa_rc_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         rd_hold,   // read of this group in progress (incl. first cycle)
  input  logic         rd_done,   // first cycle after the read ended
  output logic [N-1:0] flags,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else if (rd_done) begin
        flags[i] <= pend[i] | evt[i];
        pend[i]  <= 1'b0;
      end else if (rd_hold) begin
        pend[i]  <= pend[i] | evt[i];
      end else begin
        flags[i] <= flags[i] | evt[i];
      end
    end
  end
endmodule

// File: rtl/irqa_w0c_flags.sv
`timescale 1ns/1ps
// Write-zero-to-clear flag group; events take precedence over a clear.
module irqa_w0c_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         wr_stb,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      flags[i] <= 1'b0;
      else if (wr_stb && !wr_bits[i]) flags[i] <= evt[i];
      else                          flags[i] <= flags[i] | evt[i];
    end
  end
endmodule

// File: rtl/irqa_rd_port.sv
`timescale 1ns/1ps
// Read-cycle tracking and registered read data. The data register doubles
// as the snapshot latch for a primary status read.
module irqa_rd_port
  import irqa_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int N_PRI  = 3,
  parameter int N_EXT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PRI-1:0]  pflags,
  input  logic [N_EXT-1:0]  xflags,
  input  logic [N_PRI-1:0]  pen,
  input  logic [N_EXT-1:0]  xen,
  input  logic              summary,
  output logic              rd_hold,
  output logic              rd_done,
  output logic              rd_busy,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_PCTL  = ADDR_W'(REG_PCTL);
  localparam logic [ADDR_W-1:0] A_XCTL  = ADDR_W'(REG_XCTL);
  localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(REG_PSTAT);
  localparam logic [ADDR_W-1:0] A_XSTAT = ADDR_W'(REG_XSTAT);
  localparam int PAD_W = DATA_W - 1 - N_PRI;

  logic              rd_q;
  logic              start_pri;
  logic              in_read;
  logic [DATA_W-1:0] pst_word;
  logic [DATA_W-1:0] rd_mux;

  assign start_pri = rd_en && !rd_q && (addr == A_PSTAT);
  assign in_read   = rd_busy && rd_en;
  assign rd_hold   = start_pri || in_read;
  assign rd_done   = rd_busy && !rd_en;
  assign pst_word  = {summary, {PAD_W{1'b0}}, pflags};

  always_comb begin
    case (addr)
      A_PCTL:  rd_mux = DATA_W'(pen);
      A_XCTL:  rd_mux = DATA_W'(xen);
      A_PSTAT: rd_mux = pst_word;
      A_XSTAT: rd_mux = DATA_W'(xflags);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      rd_busy <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_q    <= rd_en;
      rd_busy <= rd_hold;
      if (start_pri)    rd_data <= pst_word;
      else if (in_read) rd_data <= rd_data;
      else if (rd_en)   rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_flag_aggr.sv
`timescale 1ns/1ps
module irq_flag_aggr
  import irqa_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int N_PRI  = 3,
  parameter int N_EXT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_PRI-1:0]  evt_pri,
  input  logic [N_EXT-1:0]  evt_ext,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int N_MAX = (N_PRI > N_EXT) ? N_PRI : N_EXT;
  localparam logic [ADDR_W-1:0] A_PCTL  = ADDR_W'(REG_PCTL);
  localparam logic [ADDR_W-1:0] A_XCTL  = ADDR_W'(REG_XCTL);
  localparam logic [ADDR_W-1:0] A_XSTAT = ADDR_W'(REG_XSTAT);

  logic [N_PRI-1:0] pen, pflags, pri_pend;
  logic [N_EXT-1:0] xen, xflags;
  logic             summary, rd_hold, rd_done, rd_busy;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:N_MAX];

  irqa_enable_reg #(.W(N_PRI)) u_pen (
    .clk(clk), .rst(rst),
    .wr_stb(wr_en && addr == A_PCTL),
    .wr_bits(wr_data[N_PRI-1:0]),
    .en(pen)
  );

  irqa_enable_reg #(.W(N_EXT)) u_xen (
    .clk(clk), .rst(rst),
    .wr_stb(wr_en && addr == A_XCTL),
    .wr_bits(wr_data[N_EXT-1:0]),
    .en(xen)
  );

  irqa_rc_flags #(.N(N_PRI)) u_pri (
    .clk(clk), .rst(rst), .evt(evt_pri),
    .rd_hold(rd_hold), .rd_done(rd_done),
    .flags(pflags), .pend(pri_pend)
  );

  irqa_w0c_flags #(.N(N_EXT)) u_ext (
    .clk(clk), .rst(rst), .evt(evt_ext),
    .wr_stb(wr_en && addr == A_XSTAT),
    .wr_bits(wr_data[N_EXT-1:0]),
    .flags(xflags)
  );

  assign summary = (|(pflags & pen)) || (|(xflags & xen));

  irqa_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PRI(N_PRI), .N_EXT(N_EXT)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .pflags(pflags), .xflags(xflags), .pen(pen), .xen(xen),
    .summary(summary), .rd_hold(rd_hold), .rd_done(rd_done),
    .rd_busy(rd_busy), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !summary;
  end
endmodule

// File: rtl/irqa_checker.sv
`timescale 1ns/1ps
module irqa_checker #(
  parameter int DATA_W = 8,
  parameter int N_PRI  = 3,
  parameter int N_EXT  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [N_PRI-1:0]  evt_pri,
  input logic [N_EXT-1:0]  evt_ext,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n,
  input logic [N_PRI-1:0]  pflags,
  input logic [N_EXT-1:0]  xflags,
  input logic [N_PRI-1:0]  pen,
  input logic [N_EXT-1:0]  xen,
  input logic [N_PRI-1:0]  pend,
  input logic              rd_busy
);
  a_r3_irq_active: assert property (@(posedge clk) disable iff (rst)
    ((|(pflags & pen)) || (|(xflags & xen))) |=> !irq_n);

  a_r3_irq_idle: assert property (@(posedge clk) disable iff (rst)
    (!(|(pflags & pen)) && !(|(xflags & xen))) |=> irq_n);

  a_r2_ext_event: assert property (@(posedge clk) disable iff (rst)
    (evt_ext != '0) |=> ((xflags & $past(evt_ext)) == $past(evt_ext)));

  a_r2_pri_event: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !rd_busy && evt_pri != '0) |=> ((pflags & $past(evt_pri)) == $past(evt_pri)));

  a_r4_read_stable: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && rd_en) |=> $stable(rd_data));

  a_r6_flags_frozen: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && rd_en) |=> $stable(pflags));

  a_r5_clear_at_end: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && !rd_en) |=> (pflags == $past(pend | evt_pri)));

  a_r7_ext_untouched: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && evt_ext == '0) |=> $stable(xflags));
endmodule

bind irq_flag_aggr irqa_checker #(
  .DATA_W(DATA_W), .N_PRI(N_PRI), .N_EXT(N_EXT)
) u_irqa_checker (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
  .evt_pri(evt_pri), .evt_ext(evt_ext), .rd_data(rd_data), .irq_n(irq_n),
  .pflags(pflags), .xflags(xflags), .pen(pen), .xen(xen),
  .pend(pri_pend), .rd_busy(rd_busy)
);

// File: tb/test_irq_flag_aggr.sv
`timescale 1ns/1ps
module test_irq_flag_aggr;
  localparam int AW = 2, DW = 8, NP = 3, NX = 3;
  localparam logic [AW-1:0] PCTL = 2'd0, XCTL = 2'd1, PSTAT = 2'd2, XSTAT = 2'd3;

  logic          clk = 1'b0, rst = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NP-1:0] evt_pri = '0;
  logic [NX-1:0] evt_ext = '0;
  logic [DW-1:0] rd_data;
  logic          irq_n;
  int n_checks = 0, n_err = 0;
  logic [DW-1:0] d;

  irq_flag_aggr #(.ADDR_W(AW), .DATA_W(DW), .N_PRI(NP), .N_EXT(NX)) i_irq_flag_aggr (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .evt_pri(evt_pri), .evt_ext(evt_ext),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  always #2.5 clk = ~clk;

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    addr = a; wr_data = v; wr_en = 1'b1;
    tick;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input int len, output logic [DW-1:0] v);
    addr = a; rd_en = 1'b1;
    tick;
    v = rd_data;
    for (int k = 1; k < len; k++) begin
      tick;
      check("R4 read word held during read", rd_data, v);
    end
    rd_en = 1'b0;
    tick;
  endtask

  task automatic pulse(input logic [NP-1:0] p, input logic [NX-1:0] x);
    evt_pri = p; evt_ext = x;
    tick;
    evt_pri = '0; evt_ext = '0;
  endtask

  task automatic clear_all;
    logic [DW-1:0] tmp;
    wr(PCTL, '0); wr(XCTL, '0);
    rd(PSTAT, 1, tmp);
    wr(XSTAT, '0);
    tick;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_n after reset", irq_n, 1);
    check("R1 rd_data after reset", rd_data, 0);
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a), 1, d);
      check("R1 register zero after reset", d, 0);
    end

    // Primary sweep: R2 R3 R5 R9 R10
    for (int pf = 0; pf < 8; pf++) begin
      for (int pe = 0; pe < 8; pe++) begin
        clear_all;
        pulse(NP'(pf), '0);
        tick;
        check("R2 flag set with enables off keeps irq_n high", irq_n, 1);
        wr(PCTL, DW'(pe));
        tick;
        check("R3 irq_n from primary flag and enable", irq_n, ((pf & pe) != 0) ? 0 : 1);
        rd(PCTL, 1, d);
        check("R10 primary enable readback", d, pe);
        rd(PSTAT, 2, d);
        check("R9 R2 primary status word", d, {((pf & pe) != 0), 4'b0000, 3'(pf)});
        rd(PSTAT, 1, d);
        check("R5 primary flags cleared by read", d, 0);
        check("R3 irq_n released after clear", irq_n, 1);
      end
    end

    // Extended sweep: R2 R3 R7 R8
    for (int xf = 0; xf < 8; xf++) begin
      for (int xe = 0; xe < 8; xe++) begin
        for (int wm = 0; wm < 8; wm++) begin
          clear_all;
          wr(XCTL, DW'(xe));
          pulse('0, NX'(xf));
          tick;
          check("R3 irq_n from extended flag and enable", irq_n, ((xf & xe) != 0) ? 0 : 1);
          rd(XSTAT, 2, d);
          check("R2 extended flags set", d, xf);
          rd(XSTAT, 1, d);
          check("R7 extended flags kept after read", d, xf);
          wr(XSTAT, {5'b10101, 3'(wm)});
          rd(XSTAT, 1, d);
          check("R8 write-zero clears, write-one keeps", d, xf & wm);
          check("R3 irq_n after partial clear", irq_n, ((xf & wm & xe) != 0) ? 0 : 1);
        end
      end
    end

    // R6: events at start, middle and end of a primary read
    clear_all;
    pulse(3'b001, '0);
    addr = PSTAT; rd_en = 1'b1; evt_pri = 3'b010;
    tick;
    evt_pri = 3'b100;
    check("R6 start-cycle event excluded from word", rd_data, 8'h01);
    tick;
    evt_pri = 3'b001;
    check("R4 R6 word held with mid-read event", rd_data, 8'h01);
    rd_en = 1'b0;
    tick;
    evt_pri = '0;
    rd(PSTAT, 1, d);
    check("R6 parked and end-cycle events applied", d, 8'h07);

    // R9: writes to primary status ignored
    clear_all;
    pulse(3'b101, '0);
    wr(PSTAT, 8'h00);
    wr(PSTAT, 8'hFF);
    rd(PSTAT, 1, d);
    check("R9 status writes ignored", d, 8'h05);
    wr(PCTL, 8'h04);
    pulse(3'b101, '0);
    rd(PSTAT, 1, d);
    check("R9 summary set with enabled flag", d, 8'h85);

    // R10: unused bits read zero
    wr(PCTL, 8'hFF);
    rd(PCTL, 1, d);
    check("R10 primary enable upper bits zero", d, 8'h07);
    wr(XCTL, 8'hF8);
    rd(XCTL, 1, d);
    check("R10 extended enable upper bits zero", d, 8'h00);

    // R8: event wins over clear in the same cycle
    clear_all;
    pulse('0, 3'b011);
    addr = XSTAT; wr_data = 8'h00; wr_en = 1'b1; evt_ext = 3'b001;
    tick;
    wr_en = 1'b0; evt_ext = '0;
    rd(XSTAT, 1, d);
    check("R8 event beats same-cycle clear", d, 8'h01);

    // R1 again: reset mid-run clears state
    wr(XCTL, 8'h01);
    tick;
    rst = 1'b1;
    tick;
    rst = 1'b0;
    check("R1 irq_n after second reset", irq_n, 1);
    rd(XSTAT, 1, d);
    check("R1 extended flags after second reset", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule